// File: doc/BRIEF.md
# Operand Addressing Mode Unit

This block turns the operand fields of an instruction for a 16-bit register-based processor into usable operands. For the source side it yields a value: read from a register, taken from the constant word after the instruction, or fetched from memory at a computed address. For the destination side it yields either the register contents or the effective memory address where a result will later be stored. The block holds the sixteen-entry register file, of which entry 0 is the program counter. It advances that counter past the extension words it consumes and writes back pointers that step after an auto-increment access.

A single `start` pulse presents both modes, both register indices, the byte/word flag and the two extension words. Operations that need no memory finish on the next clock edge. A source that lives in memory is fetched over a simple read handshake: address plus strobe, held until ready. Then `done` pulses with all results valid. A separate write port lets the surrounding datapath load any register while the unit is idle.

Top module: `opnd_resolver`

## Requirements
- R1: Mode codes are 0 register, 1 indexed, 2 PC-relative, 3 absolute, 4 indirect, 5 indirect auto-increment, 6 immediate and 7 reserved. A register-mode source is the register value. `done` rises on the clock edge that samples `start` when no memory read is needed, and `mem_rd` stays low throughout.
- R2: Indexed mode uses the address extension word plus the selected register, modulo 2^16.
- R3: PC-relative mode uses the address R0 holds at that extension word plus the word itself.
- R4: Absolute mode uses the extension word itself as the address.
- R5: Indirect mode reads memory at the register's value and writes nothing back.
- R6: Auto-increment reads at the register's value, then reports and writes back the register plus 2, or plus 1 for a byte access. R0 and R1 always step by 2. The R0 step appears only in `pc_out`.
- R7: Immediate mode returns the source extension word as the source value.
- R8: Destination modes 4 to 7 and source mode 7 set `illegal` with `done` one edge after `start`. They issue no memory read and change no register.
- R9: The source extension word sits at the starting R0. The destination word sits after it, and after the R0 auto-increment step if there is one. `pc_out` and R0 become the starting R0 plus 2 per word consumed, plus that step.
- R10: `mem_rd` holds `mem_addr` stable until `mem_rdy` is sampled high. `done` follows on the next edge.
- R11: Byte operands are zero-extended. Register and immediate operands use the low byte. A byte read from memory takes the high half when the address is odd and the low half when it is even.
- R12: Both sides use register values from the `start` cycle. Write-backs land when `done` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears registers and state |
| start | input | 1 | Begin resolving; ignored while a read is pending |
| src_mode | input | 3 | Source mode code |
| src_reg | input | 4 | Source register index |
| dst_mode | input | 3 | Destination mode code |
| dst_reg | input | 4 | Destination register index |
| byte_op | input | 1 | 1 for byte access, 0 for word |
| src_ext | input | 16 | Source extension word |
| dst_ext | input | 16 | Destination extension word |
| rf_we | input | 1 | External register write enable |
| rf_widx | input | 4 | External write index |
| rf_wdata | input | 16 | External write data |
| mem_addr | output | 16 | Memory read address |
| mem_rd | output | 1 | Memory read strobe |
| mem_rdata | input | 16 | Memory read data |
| mem_rdy | input | 1 | Memory read data valid |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Mode combination rejected |
| src_val | output | 16 | Resolved source value |
| src_mem | output | 1 | Source came from memory |
| src_addr | output | 16 | Source effective address |
| dst_data | output | 16 | Destination register value or address |
| dst_mem | output | 1 | dst_data is a memory address |
| wb_en | output | 1 | Pointer write-back performed |
| wb_idx | output | 4 | Pointer register index |
| wb_val | output | 16 | Pointer value written |
| pc_out | output | 16 | Updated program counter |

## Verification
A register-only or illegal request is due one edge after `start`, so the bench samples `done` at the first falling edge that follows. A memory source is due one edge after the edge that sees `mem_rdy`. The bench holds ready back for a chosen 0 to 3 cycles and expects `done` exactly that many cycles later plus two. It checks the read address on every falling edge while `mem_rd` is high. A shadow register file in the bench predicts every later operand, so a wrong or missing write-back shows up in the next operation that reads that register.

// File: rtl/opnd_pkg.sv
package opnd_pkg;

    typedef enum logic [2:0] {
        AM_REG = 3'd0,
        AM_IDX = 3'd1,
        AM_SYM = 3'd2,
        AM_ABS = 3'd3,
        AM_IND = 3'd4,
        AM_INC = 3'd5,
        AM_IMM = 3'd6,
        AM_RSV = 3'd7
    } amode_e;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_READ = 1'b1
    } fsm_e;

endpackage

// File: rtl/opnd_regs.sv
module opnd_regs #(
    parameter int DW   = 16,
    parameter int NREG = 16,
    localparam int IW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] ra_idx,
    output logic [DW-1:0] ra_val,
    input  logic [IW-1:0] rb_idx,
    output logic [DW-1:0] rb_val,
    output logic [DW-1:0] pc_val,
    input  logic          ext_we,
    input  logic [IW-1:0] ext_idx,
    input  logic [DW-1:0] ext_data,
    input  logic          pc_we,
    input  logic [DW-1:0] pc_data,
    input  logic          ptr_we,
    input  logic [IW-1:0] ptr_idx,
    input  logic [DW-1:0] ptr_data
);
    logic [NREG-1:0][DW-1:0] bank;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [DW-1:0] r_q;
        // pointer step wins, then program counter, then the external port
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                r_q <= '0;
            else if (ptr_we && ptr_idx == IW'(g))
                r_q <= ptr_data;
            else if (pc_we && g == 0)
                r_q <= pc_data;
            else if (ext_we && ext_idx == IW'(g))
                r_q <= ext_data;
        end
        assign bank[g] = r_q;
    end

    assign ra_val = bank[ra_idx];
    assign rb_val = bank[rb_idx];
    assign pc_val = bank[0];
endmodule

// File: rtl/opnd_ea.sv
module opnd_ea
    import opnd_pkg::*;
#(
    parameter int DW = 16
) (
    input  amode_e        mode,
    input  logic [DW-1:0] reg_val,
    input  logic [DW-1:0] ext_word,
    input  logic [DW-1:0] pc_at_ext,
    output logic [DW-1:0] ea,
    output logic          uses_ext,
    output logic          uses_mem
);
    always_comb begin
        ea       = '0;
        uses_ext = 1'b0;
        uses_mem = 1'b0;
        unique case (mode)
            AM_IDX: begin ea = ext_word + reg_val;   uses_ext = 1'b1; uses_mem = 1'b1; end
            AM_SYM: begin ea = pc_at_ext + ext_word; uses_ext = 1'b1; uses_mem = 1'b1; end
            AM_ABS: begin ea = ext_word;             uses_ext = 1'b1; uses_mem = 1'b1; end
            AM_IND,
            AM_INC: begin ea = reg_val;              uses_mem = 1'b1; end
            AM_IMM: begin uses_ext = 1'b1; end
            default: ;
        endcase
    end
endmodule

// File: rtl/opnd_resolver.sv
module opnd_resolver
    import opnd_pkg::*;
#(
    parameter int DW   = 16,
    parameter int NREG = 16,
    localparam int IW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [2:0]    src_mode,
    input  logic [IW-1:0] src_reg,
    input  logic [2:0]    dst_mode,
    input  logic [IW-1:0] dst_reg,
    input  logic          byte_op,
    input  logic [DW-1:0] src_ext,
    input  logic [DW-1:0] dst_ext,
    input  logic          rf_we,
    input  logic [IW-1:0] rf_widx,
    input  logic [DW-1:0] rf_wdata,
    output logic [DW-1:0] mem_addr,
    output logic          mem_rd,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_rdy,
    output logic          done,
    output logic          illegal,
    output logic [DW-1:0] src_val,
    output logic          src_mem,
    output logic [DW-1:0] src_addr,
    output logic [DW-1:0] dst_data,
    output logic          dst_mem,
    output logic          wb_en,
    output logic [IW-1:0] wb_idx,
    output logic [DW-1:0] wb_val,
    output logic [DW-1:0] pc_out
);
    localparam logic [DW-1:0] WSTEP = DW'(2);
    localparam logic [DW-1:0] BSTEP = DW'(1);

    typedef struct packed {
        fsm_e          st;
        logic          done;
        logic          illegal;
        logic          byte_op;
        logic          src_mem;
        logic          dst_mem;
        logic          ptr_pend;
        logic          wb_en;
        logic [DW-1:0] src_val;
        logic [DW-1:0] src_addr;
        logic [DW-1:0] dst_data;
        logic [DW-1:0] ptr_val;
        logic [DW-1:0] pc_new;
        logic [IW-1:0] ptr_idx;
    } state_t;

    state_t s_d, s_q;

    function automatic logic [DW-1:0] lo_byte(input logic [DW-1:0] v);
        return {{(DW-8){1'b0}}, v[7:0]};
    endfunction

    amode_e        sm, dm;
    logic [DW-1:0] s_reg_v, d_reg_v, pc0;
    logic [DW-1:0] s_ea, d_ea, d_pc, pc_fin, step, rd_sel;
    logic          s_ext, s_mem, d_ext, d_mem, pc_inc, bad_mode, fire;

    assign sm = amode_e'(src_mode);
    assign dm = amode_e'(dst_mode);

    opnd_regs #(.DW(DW), .NREG(NREG)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .ra_idx   (src_reg),
        .ra_val   (s_reg_v),
        .rb_idx   (dst_reg),
        .rb_val   (d_reg_v),
        .pc_val   (pc0),
        .ext_we   (rf_we),
        .ext_idx  (rf_widx),
        .ext_data (rf_wdata),
        .pc_we    (fire),
        .pc_data  (s_d.pc_new),
        .ptr_we   (fire && s_d.ptr_pend),
        .ptr_idx  (s_d.ptr_idx),
        .ptr_data (s_d.ptr_val)
    );

    // source extension word sits at the starting program counter
    opnd_ea #(.DW(DW)) u_src_ea (
        .mode      (sm),
        .reg_val   (s_reg_v),
        .ext_word  (src_ext),
        .pc_at_ext (pc0),
        .ea        (s_ea),
        .uses_ext  (s_ext),
        .uses_mem  (s_mem)
    );

    opnd_ea #(.DW(DW)) u_dst_ea (
        .mode      (dm),
        .reg_val   (d_reg_v),
        .ext_word  (dst_ext),
        .pc_at_ext (d_pc),
        .ea        (d_ea),
        .uses_ext  (d_ext),
        .uses_mem  (d_mem)
    );

    always_comb begin
        bad_mode = (sm == AM_RSV) || dst_mode[2];
        pc_inc   = (sm == AM_INC) && (src_reg == '0);
        step     = (byte_op && src_reg > IW'(1)) ? BSTEP : WSTEP;
        d_pc     = pc0 + (s_ext ? WSTEP : '0) + (pc_inc ? WSTEP : '0);
        pc_fin   = d_pc + (d_ext ? WSTEP : '0);
        rd_sel   = s_q.byte_op ? (s_q.src_addr[0] ? lo_byte(mem_rdata >> 8)
                                                  : lo_byte(mem_rdata))
                               : mem_rdata;
    end

    always_comb begin
        s_d       = s_q;
        s_d.done  = 1'b0;
        s_d.wb_en = 1'b0;
        fire      = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    s_d.illegal = bad_mode;
                    s_d.byte_op = byte_op;
                    if (bad_mode) begin
                        s_d.done     = 1'b1;
                        s_d.src_mem  = 1'b0;
                        s_d.ptr_pend = 1'b0;
                    end else begin
                        s_d.src_mem  = s_mem;
                        s_d.src_addr = s_ea;
                        s_d.dst_mem  = d_mem;
                        s_d.dst_data = (dm == AM_REG)
                                       ? (byte_op ? lo_byte(d_reg_v) : d_reg_v) : d_ea;
                        s_d.ptr_pend = (sm == AM_INC) && !pc_inc;
                        s_d.ptr_idx  = src_reg;
                        s_d.ptr_val  = s_reg_v + step;
                        s_d.pc_new   = pc_fin;
                        if (sm == AM_IMM)
                            s_d.src_val = byte_op ? lo_byte(src_ext) : src_ext;
                        else if (sm == AM_REG)
                            s_d.src_val = byte_op ? lo_byte(s_reg_v) : s_reg_v;
                        else
                            s_d.src_val = '0;
                        if (s_mem) begin
                            s_d.st = ST_READ;
                        end else begin
                            s_d.done = 1'b1;
                            fire     = 1'b1;
                        end
                    end
                end
            end
            ST_READ: begin
                if (mem_rdy) begin
                    s_d.src_val = rd_sel;
                    s_d.done    = 1'b1;
                    s_d.wb_en   = s_q.ptr_pend;
                    s_d.st      = ST_IDLE;
                    fire        = 1'b1;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign mem_rd   = (s_q.st == ST_READ);
    assign mem_addr = s_q.src_addr;
    assign done     = s_q.done;
    assign illegal  = s_q.illegal;
    assign src_val  = s_q.src_val;
    assign src_mem  = s_q.src_mem;
    assign src_addr = s_q.src_addr;
    assign dst_data = s_q.dst_data;
    assign dst_mem  = s_q.dst_mem;
    assign wb_en    = s_q.wb_en;
    assign wb_idx   = s_q.ptr_idx;
    assign wb_val   = s_q.ptr_val;
    assign pc_out   = s_q.pc_new;
endmodule

// File: rtl/opnd_resolver_chk.sv
module opnd_resolver_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_rd,
    input logic          mem_rdy,
    input logic [DW-1:0] mem_addr,
    input logic          done,
    input logic          illegal,
    input logic          src_mem,
    input logic [DW-1:0] src_addr,
    input logic          wb_en,
    input logic [DW-1:0] wb_val
);
    AST_RD_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !mem_rdy) |=> (mem_rd && $stable(mem_addr))); // R10

    AST_DONE_AFTER_RDY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && mem_rdy) |=> done); // R10

    AST_NO_RD_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_rd); // R10

    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (done && illegal) |-> (!src_mem && !wb_en)); // R8

    AST_WB_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (done && src_mem)); // R6

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> ((wb_val - src_addr) == DW'(1) || (wb_val - src_addr) == DW'(2))); // R6
endmodule

bind opnd_resolver opnd_resolver_chk #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_rd   (mem_rd),
    .mem_rdy  (mem_rdy),
    .mem_addr (mem_addr),
    .done     (done),
    .illegal  (illegal),
    .src_mem  (src_mem),
    .src_addr (src_addr),
    .wb_en    (wb_en),
    .wb_val   (wb_val)
);

// File: tb/opnd_resolver_test.sv
module opnd_resolver_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  src_mode = '0, dst_mode = '0;
    logic [3:0]  src_reg = '0, dst_reg = '0;
    logic        byte_op = 1'b0;
    logic [15:0] src_ext = '0, dst_ext = '0;
    logic        rf_we = 1'b0;
    logic [3:0]  rf_widx = '0;
    logic [15:0] rf_wdata = '0;
    logic [15:0] mem_addr;
    logic        mem_rd;
    logic [15:0] mem_rdata = '0;
    logic        mem_rdy = 1'b0;
    logic        done, illegal, src_mem, dst_mem, wb_en;
    logic [15:0] src_val, src_addr, dst_data, wb_val, pc_out;
    logic [3:0]  wb_idx;

    int n_chk = 0;
    int n_err = 0;
    logic [15:0] sh [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    opnd_resolver uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .src_mode(src_mode), .src_reg(src_reg), .dst_mode(dst_mode), .dst_reg(dst_reg),
        .byte_op(byte_op), .src_ext(src_ext), .dst_ext(dst_ext),
        .rf_we(rf_we), .rf_widx(rf_widx), .rf_wdata(rf_wdata),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata), .mem_rdy(mem_rdy),
        .done(done), .illegal(illegal), .src_val(src_val), .src_mem(src_mem),
        .src_addr(src_addr), .dst_data(dst_data), .dst_mem(dst_mem),
        .wb_en(wb_en), .wb_idx(wb_idx), .wb_val(wb_val), .pc_out(pc_out)
    );

    function automatic logic [15:0] mem_fn(input logic [15:0] a);
        return {a[7:0], a[15:8]} ^ 16'h5A3C;
    endfunction

    function automatic logic [15:0] lo8(input logic [15:0] v);
        return {8'h00, v[7:0]};
    endfunction

    function automatic string mode_tag(input logic [2:0] m);
        case (m)
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            3'd5: return "R6";
            3'd6: return "R7";
            default: return "R1";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic load(input logic [3:0] idx, input logic [15:0] val);
        @(negedge clk);
        rf_we = 1'b1; rf_widx = idx; rf_wdata = val;
        @(negedge clk);
        rf_we = 1'b0;
        sh[idx] = val;
    endtask

    task automatic run_op(input logic [2:0] sm, input logic [3:0] sr,
                          input logic [2:0] dm, input logic [3:0] dr,
                          input logic bo, input logic [15:0] se, input logic [15:0] de,
                          input int lat, input string dtag);
        logic        e_ill, e_sext, e_smem, e_ptr;
        logic [15:0] pc0, e_ea, d_pc, e_pc, e_dst, e_src, e_ptrv, w;
        int          cyc;
        string       stag;
        pc0    = sh[0];
        e_ill  = (sm == 3'd7) || dm[2];
        e_sext = (sm == 3'd1) || (sm == 3'd2) || (sm == 3'd3) || (sm == 3'd6);
        e_smem = (sm >= 3'd1) && (sm <= 3'd5);
        case (sm)
            3'd1: e_ea = se + sh[sr];
            3'd2: e_ea = pc0 + se;
            3'd3: e_ea = se;
            default: e_ea = sh[sr];
        endcase
        d_pc = pc0 + (e_sext ? 16'd2 : 16'd0) + ((sm == 3'd5 && sr == 4'd0) ? 16'd2 : 16'd0);
        case (dm)
            3'd1: e_dst = de + sh[dr];
            3'd2: e_dst = d_pc + de;
            3'd3: e_dst = de;
            default: e_dst = bo ? lo8(sh[dr]) : sh[dr];
        endcase
        e_pc = d_pc + ((dm != 3'd0) ? 16'd2 : 16'd0);
        w = mem_fn(e_ea);
        if (sm == 3'd0)      e_src = bo ? lo8(sh[sr]) : sh[sr];
        else if (sm == 3'd6) e_src = bo ? lo8(se) : se;
        else                 e_src = bo ? (e_ea[0] ? {8'h00, w[15:8]} : lo8(w)) : w;
        e_ptr  = (sm == 3'd5) && (sr != 4'd0);
        e_ptrv = sh[sr] + ((bo && sr > 4'd1) ? 16'd1 : 16'd2);
        stag   = (bo && e_smem) ? "R11" : mode_tag(sm);
        if (dtag == "") dtag = mode_tag(dm);

        @(negedge clk);
        src_mode = sm; src_reg = sr; dst_mode = dm; dst_reg = dr;
        byte_op = bo; src_ext = se; dst_ext = de; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!done && cyc < 40) begin
            if (mem_rd) begin
                chk("R10", {16'h0, mem_addr}, {16'h0, e_ea});
                if (e_ill || !e_smem) chk(e_ill ? "R8" : "R1", 32'(mem_rd), 32'd0);
                if (cyc - 1 == lat) begin
                    mem_rdy = 1'b1;
                    mem_rdata = mem_fn(mem_addr);
                end
            end
            @(negedge clk);
            mem_rdy = 1'b0;
            mem_rdata = 16'hDEAD;
            cyc++;
        end
        chk(e_smem && !e_ill ? "R10" : (e_ill ? "R8" : "R1"), 32'(cyc),
            (e_smem && !e_ill) ? 32'(lat + 2) : 32'd1);
        chk("R8", 32'(illegal), 32'(e_ill));
        if (!e_ill) begin
            chk(stag, {16'h0, src_val}, {16'h0, e_src});
            chk(stag, 32'(src_mem), 32'(e_smem));
            if (e_smem) chk(stag, {16'h0, src_addr}, {16'h0, e_ea});
            chk(dtag, {16'h0, dst_data}, {16'h0, e_dst});
            chk(dtag, 32'(dst_mem), 32'(dm != 3'd0));
            chk("R6", 32'(wb_en), 32'(e_ptr));
            if (e_ptr) begin
                chk("R6", 32'(wb_idx), 32'(sr));
                chk("R6", {16'h0, wb_val}, {16'h0, e_ptrv});
            end
            chk("R9", {16'h0, pc_out}, {16'h0, e_pc});
            sh[0] = e_pc;
            if (e_ptr) sh[sr] = e_ptrv;
        end else begin
            chk("R8", 32'(wb_en), 32'd0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 16; i++) sh[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", 32'(mem_rd), 32'd0);
        chk("R1", 32'(done), 32'd0);
        run_op(3'd0, 4'd4, 3'd0, 4'd5, 1'b0, 16'h0, 16'h0, 0, "");   // reset value R1
        load(4'd0, 16'h4000);
        load(4'd1, 16'h0300);
        load(4'd4, 16'h1234);
        load(4'd5, 16'h0200);
        load(4'd6, 16'h0501);
        run_op(3'd0, 4'd4, 3'd0, 4'd5, 1'b0, 16'h0, 16'h0, 0, "");
        run_op(3'd0, 4'd4, 3'd0, 4'd4, 1'b1, 16'h0, 16'h0, 0, "R11");
        run_op(3'd1, 4'd5, 3'd0, 4'd4, 1'b0, 16'h0002, 16'h0, 3, "");
        run_op(3'd2, 4'd7, 3'd0, 4'd4, 1'b0, 16'hFFF0, 16'h0, 1, "");
        run_op(3'd3, 4'd0, 3'd0, 4'd4, 1'b1, 16'h0123, 16'h0, 0, "");
        run_op(3'd3, 4'd0, 3'd0, 4'd4, 1'b1, 16'h0124, 16'h0, 2, "");
        run_op(3'd4, 4'd5, 3'd0, 4'd4, 1'b0, 16'h0, 16'h0, 1, "");
        run_op(3'd5, 4'd5, 3'd0, 4'd4, 1'b0, 16'h0, 16'h0, 0, "");
        run_op(3'd5, 4'd6, 3'd0, 4'd4, 1'b1, 16'h0, 16'h0, 0, "");
        run_op(3'd5, 4'd1, 3'd0, 4'd4, 1'b1, 16'h0, 16'h0, 0, "");
        run_op(3'd5, 4'd0, 3'd2, 4'd4, 1'b0, 16'h0, 16'h0010, 0, "R9");
        run_op(3'd6, 4'd3, 3'd0, 4'd4, 1'b1, 16'hBEEF, 16'h0, 0, "");
        run_op(3'd1, 4'd4, 3'd3, 4'd4, 1'b0, 16'h0010, 16'h8000, 1, "R9");
        run_op(3'd1, 4'd4, 3'd2, 4'd4, 1'b0, 16'h0010, 16'h0100, 0, "R9");
        run_op(3'd5, 4'd5, 3'd1, 4'd5, 1'b0, 16'h0, 16'h0010, 0, "R12");
        run_op(3'd0, 4'd5, 3'd4, 4'd4, 1'b0, 16'h0, 16'h0, 0, "");
        run_op(3'd7, 4'd5, 3'd0, 4'd4, 1'b0, 16'h0, 16'h0, 0, "");
        run_op(3'd0, 4'd5, 3'd0, 4'd0, 1'b0, 16'h0, 16'h0, 0, "R8");
        for (int n = 0; n < 400; n++) begin
            logic [2:0] sm, dm;
            if ($urandom_range(0, 7) == 0)
                load(4'($urandom_range(0, 15)), 16'($urandom));
            sm = 3'($urandom_range(0, 7));
            dm = ($urandom_range(0, 5) == 0) ? 3'($urandom_range(4, 7)) : 3'($urandom_range(0, 3));
            run_op(sm, 4'($urandom_range(0, 15)), dm, 4'($urandom_range(0, 15)),
                   1'($urandom_range(0, 1)), 16'($urandom), 16'($urandom),
                   $urandom_range(0, 3), "");
        end
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule